// File: doc/BRIEF.md
# Branch Target Address Generator

This block works out the next program counter for the jump and call instructions of an 8-bit microcontroller that has a 64K-byte program space. Each cycle, the core presents several inputs: the address of the byte that follows the current instruction, a small code naming the addressing form, the opcode byte, the two operand bytes, the accumulator, the 16-bit data pointer and the branch condition it has already evaluated. One clock later, the block returns the 16-bit target and a taken flag.

Four target forms are built:
- A full 16-bit absolute address.
- An 11-bit in-page address, whose three upper bits are packed into the top of the opcode.
- A signed 8-bit offset from the next-instruction address. For two-byte jumps the offset sits in the first operand byte. For three-byte bit-test jumps it sits in the second.
- The sum of the accumulator and the data pointer.

Stack handling for calls and returns, condition evaluation and fetch timing stay in the core.

Top module: `branch_target_gen`

## Requirements
- R1: While rst_ni is low, valid_o and taken_o are 0 and target_o is 0x0000.
- R2: valid_o equals valid_i of the previous clock; target_o and taken_o update one clock after a cycle with valid_i high.
- R3: In a cycle with valid_i low, target_o and taken_o keep their values on the next clock, whatever the other inputs do.
- R4: kind_i = 1 (absolute): target_o = {opnd1_i, opnd2_i}, with opnd1_i as the high byte, and taken_o = 1 regardless of cond_i.
- R5: kind_i = 2 (in-page): target_o = {next_pc_i[15:11], opcode_i[7:5], opnd1_i} and taken_o = 1 regardless of cond_i; the page comes from the next-instruction address, not from the instruction's own address.
- R6: kind_i = 3 (short relative) with cond_i = 1: target_o = next_pc_i + sign-extended opnd1_i, so the offset spans -128 to +127, and taken_o = 1.
- R7: kind_i = 4 (bit-test relative) with cond_i = 1: as R6, but the offset is taken from opnd2_i and opnd1_i has no effect.
- R8: kind_i = 3 or 4 with cond_i = 0: taken_o = 0 and target_o = next_pc_i.
- R9: kind_i = 5 (indirect): target_o = zero-extended acc_i + dptr_i, and taken_o = 1 regardless of cond_i.
- R10: kind_i = 0, 6 or 7 (no branch): taken_o = 0 and target_o = next_pc_i.
- R11: The relative and indirect sums wrap modulo 65536, with no carry out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request present this cycle |
| kind_i | input | 3 | Addressing form: 0 none, 1 absolute, 2 in-page, 3 short relative, 4 bit-test relative, 5 indirect |
| cond_i | input | 1 | Branch condition from the core (relative forms only) |
| next_pc_i | input | 16 | Address of the byte after the current instruction |
| opcode_i | input | 8 | Opcode byte |
| opnd1_i | input | 8 | First operand byte |
| opnd2_i | input | 8 | Second operand byte |
| acc_i | input | 8 | Accumulator |
| dptr_i | input | 16 | Data pointer |
| valid_o | output | 1 | Result present |
| taken_o | output | 1 | Branch taken |
| target_o | output | 16 | Next program counter |

## Verification
The only state in the block is the output register, so a wrong value there shows at target_o or taken_o on the very clock after the request. The reference model recomputes the result on every clock.

The edge cases get directed stimulus:
- An in-page jump placed just below a 2K boundary, and one placed just after it, which catches a page taken from the wrong address.
- Offsets of +127 and -128, which catch a missing sign extension.
- Sums that cross 0xFFFF, which catch a wrong carry width.

A cycle with valid_i low that changes every other input catches a register that fails to hold.

// File: rtl/bta_pkg.sv
package bta_pkg;
  localparam int unsigned KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    BK_NONE    = 3'd0,
    BK_ABS     = 3'd1,
    BK_PAGE    = 3'd2,
    BK_REL_SH  = 3'd3,
    BK_REL_BIT = 3'd4,
    BK_IND     = 3'd5
  } br_kind_e;
endpackage

// File: rtl/bta_page_gen.sv
module bta_page_gen #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PAGE_W = 11
) (
  input  logic [ADDR_W-1:0] next_pc_i,
  input  logic [DATA_W-1:0] opcode_i,
  input  logic [DATA_W-1:0] low_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned SEL_W = PAGE_W - DATA_W;

  // page kept from the next-instruction address, selector from the opcode top bits
  assign addr_o = {next_pc_i[ADDR_W-1:PAGE_W], opcode_i[DATA_W-1 -: SEL_W], low_i};
endmodule

// File: rtl/bta_rel_gen.sv
module bta_rel_gen #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DATA_W-1:0] off_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned EXT_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] off_ext;

  assign off_ext = {{EXT_W{off_i[DATA_W-1]}}, off_i};
  assign addr_o  = base_i + off_ext;
endmodule

// File: rtl/bta_ind_gen.sv
module bta_ind_gen #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] acc_i,
  input  logic [ADDR_W-1:0] ptr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned EXT_W = ADDR_W - DATA_W;

  assign addr_o = {{EXT_W{1'b0}}, acc_i} + ptr_i;
endmodule

// File: rtl/branch_target_gen.sv
module branch_target_gen
  import bta_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PAGE_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        kind_i,
  input  logic              cond_i,
  input  logic [ADDR_W-1:0] next_pc_i,
  input  logic [DATA_W-1:0] opcode_i,
  input  logic [DATA_W-1:0] opnd1_i,
  input  logic [DATA_W-1:0] opnd2_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [ADDR_W-1:0] dptr_i,
  output logic              valid_o,
  output logic              taken_o,
  output logic [ADDR_W-1:0] target_o
);
  br_kind_e          kind;
  logic [ADDR_W-1:0] abs_addr, page_addr, rel_addr, ind_addr;
  logic [DATA_W-1:0] rel_off;
  logic [ADDR_W-1:0] nxt_target;
  logic              nxt_taken;

  assign kind     = br_kind_e'(kind_i);
  assign abs_addr = {opnd1_i, opnd2_i};
  // bit-test jumps carry the offset in the third byte
  assign rel_off  = (kind == BK_REL_BIT) ? opnd2_i : opnd1_i;

  bta_page_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_page (
    .next_pc_i (next_pc_i),
    .opcode_i  (opcode_i),
    .low_i     (opnd1_i),
    .addr_o    (page_addr)
  );

  bta_rel_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rel (
    .base_i (next_pc_i),
    .off_i  (rel_off),
    .addr_o (rel_addr)
  );

  bta_ind_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ind (
    .acc_i  (acc_i),
    .ptr_i  (dptr_i),
    .addr_o (ind_addr)
  );

  always_comb begin
    nxt_taken  = 1'b0;
    nxt_target = next_pc_i;
    unique case (kind)
      BK_ABS:  begin nxt_taken = 1'b1; nxt_target = abs_addr;  end
      BK_PAGE: begin nxt_taken = 1'b1; nxt_target = page_addr; end
      BK_IND:  begin nxt_taken = 1'b1; nxt_target = ind_addr;  end
      BK_REL_SH, BK_REL_BIT: begin
        nxt_taken = cond_i;
        if (cond_i) nxt_target = rel_addr;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      taken_o  <= 1'b0;
      target_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        taken_o  <= nxt_taken;
        target_o <= nxt_target;
      end
    end
  end
endmodule

// File: rtl/bta_checker.sv
module bta_checker #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PAGE_W = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        kind_i,
  input logic              cond_i,
  input logic [ADDR_W-1:0] next_pc_i,
  input logic [DATA_W-1:0] opcode_i,
  input logic [DATA_W-1:0] opnd1_i,
  input logic [DATA_W-1:0] opnd2_i,
  input logic              valid_o,
  input logic              taken_o,
  input logic [ADDR_W-1:0] target_o
);
  localparam int unsigned SEL_W = PAGE_W - DATA_W;

  always_comb begin
    if (!rst_ni) AST_RESET_CLEAR: assert (!valid_o && !taken_o && target_o == '0); // R1
  end

  AST_VALID_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i)) ; // R2

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(target_o) && $stable(taken_o)); // R3

  AST_ABS_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && kind_i == 3'd1 |=> taken_o && target_o == {$past(opnd1_i), $past(opnd2_i)}); // R4

  AST_PAGE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && kind_i == 3'd2 |=> taken_o
      && target_o[ADDR_W-1:PAGE_W] == $past(next_pc_i[ADDR_W-1:PAGE_W])
      && target_o[PAGE_W-1:DATA_W] == $past(opcode_i[DATA_W-1 -: SEL_W])
      && target_o[DATA_W-1:0] == $past(opnd1_i)); // R5

  AST_REL_NOT_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (kind_i == 3'd3 || kind_i == 3'd4) && !cond_i
      |=> !taken_o && target_o == $past(next_pc_i)); // R8

  AST_NO_BRANCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (kind_i == 3'd0 || kind_i > 3'd5)
      |=> !taken_o && target_o == $past(next_pc_i)); // R10
endmodule

bind branch_target_gen bta_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .kind_i    (kind_i),
  .cond_i    (cond_i),
  .next_pc_i (next_pc_i),
  .opcode_i  (opcode_i),
  .opnd1_i   (opnd1_i),
  .opnd2_i   (opnd2_i),
  .valid_o   (valid_o),
  .taken_o   (taken_o),
  .target_o  (target_o)
);

// File: tb/tb_branch_target_gen.sv
`timescale 1ns/1ps
module tb_branch_target_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  kind_i = '0;
  logic        cond_i = 1'b0;
  logic [15:0] next_pc_i = '0;
  logic [7:0]  opcode_i = '0, opnd1_i = '0, opnd2_i = '0, acc_i = '0;
  logic [15:0] dptr_i = '0;
  logic        valid_o, taken_o;
  logic [15:0] target_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int    exp_valid = 0, exp_taken = 0, exp_target = 0;
  string exp_tag = "R1";

  branch_target_gen dut (
    .clk_i, .rst_ni, .valid_i, .kind_i, .cond_i, .next_pc_i, .opcode_i,
    .opnd1_i, .opnd2_i, .acc_i, .dptr_i, .valid_o, .taken_o, .target_o
  );

  always #10 clk_i = ~clk_i;

  function automatic int sext8(int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  // behavioural reference
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_valid = 0; exp_taken = 0; exp_target = 0; exp_tag = "R1";
    end else begin
      exp_valid = int'(valid_i);
      if (valid_i) begin
        int pc;
        pc = int'(next_pc_i);
        exp_taken = 0; exp_target = pc; exp_tag = "R10";
        case (int'(kind_i))
          1: begin exp_taken = 1; exp_target = int'(opnd1_i) * 256 + int'(opnd2_i); exp_tag = "R4"; end
          2: begin
            exp_taken = 1;
            exp_target = (pc / 2048) * 2048 + (int'(opcode_i) / 32) * 256 + int'(opnd1_i);
            exp_tag = "R5";
          end
          3: if (cond_i) begin exp_taken = 1; exp_target = (pc + sext8(int'(opnd1_i)) + 65536) % 65536; exp_tag = "R6/R11"; end
             else exp_tag = "R8";
          4: if (cond_i) begin exp_taken = 1; exp_target = (pc + sext8(int'(opnd2_i)) + 65536) % 65536; exp_tag = "R7/R11"; end
             else exp_tag = "R8";
          5: begin exp_taken = 1; exp_target = (int'(acc_i) + int'(dptr_i)) % 65536; exp_tag = "R9/R11"; end
          default: ;
        endcase
      end else exp_tag = "R3";
    end
  end

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk_i) begin
    if (!done) begin
      check("R2 valid", int'(valid_o), exp_valid);
      check({exp_tag, " taken"}, int'(taken_o), exp_taken);
      check({exp_tag, " target"}, int'(target_o), exp_target);
    end
  end

  task automatic drive(bit v, int k, bit c, int pc, int op, int b1, int b2, int a, int dp);
    @(negedge clk_i);
    valid_i = v; kind_i = 3'(k); cond_i = c; next_pc_i = 16'(pc);
    opcode_i = 8'(op); opnd1_i = 8'(b1); opnd2_i = 8'(b2); acc_i = 8'(a); dptr_i = 16'(dp);
  endtask

  initial begin
    #5;
    check("R1 valid", int'(valid_o), 0);
    check("R1 taken", int'(taken_o), 0);
    check("R1 target", int'(target_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    drive(1, 1, 0, 16'h0100, 8'h02, 8'h12, 8'h34, 0, 0);           // R4 absolute, cond ignored
    drive(1, 1, 1, 16'h0100, 8'h12, 8'hFF, 8'hFF, 0, 0);           // R4 top of space
    drive(1, 2, 0, 16'h07FE, 8'hE1, 8'h55, 8'h00, 0, 0);           // R5 last page-0 slot
    drive(1, 2, 1, 16'h0800, 8'h01, 8'h10, 8'h00, 0, 0);           // R5 next address in page 1
    drive(1, 2, 1, 16'hFFFF, 8'h41, 8'hAA, 8'h00, 0, 0);           // R5 top page
    drive(1, 3, 1, 16'h1000, 8'h80, 8'h7F, 8'h00, 0, 0);           // R6 +127
    drive(1, 3, 1, 16'h1000, 8'h80, 8'h80, 8'h00, 0, 0);           // R6 -128
    drive(1, 3, 1, 16'hFFFE, 8'h80, 8'h05, 8'h00, 0, 0);           // R11 wrap up
    drive(1, 3, 1, 16'h0002, 8'h80, 8'h80, 8'h00, 0, 0);           // R11 wrap down
    drive(1, 4, 1, 16'h2000, 8'h20, 8'h7F, 8'hFE, 0, 0);           // R7 offset from byte 2
    drive(1, 4, 0, 16'h2000, 8'h20, 8'h7F, 8'hFE, 0, 0);           // R8
    drive(1, 3, 0, 16'h3456, 8'h40, 8'h10, 8'h00, 0, 0);           // R8
    drive(1, 5, 0, 16'h0000, 8'h73, 0, 0, 8'hFF, 16'hFF80);        // R9/R11 wrap
    drive(1, 5, 1, 16'h0000, 8'h73, 0, 0, 8'h10, 16'h1234);        // R9
    drive(0, 1, 1, 16'hABCD, 8'h02, 8'h99, 8'h88, 8'h77, 16'h6666);// R3 hold
    drive(0, 5, 1, 16'h1111, 8'h73, 8'h01, 8'h02, 8'h03, 16'h0004);// R3 hold
    drive(1, 0, 1, 16'h4321, 8'h00, 8'h11, 8'h22, 0, 0);           // R10
    drive(1, 6, 1, 16'h5555, 8'h00, 8'h11, 8'h22, 0, 0);           // R10
    drive(1, 7, 1, 16'hFFFF, 8'h00, 8'h11, 8'h22, 0, 0);           // R10
    for (int i = 0; i < 400; i++)
      drive(($urandom % 4) != 0, $urandom % 8, $urandom % 2, $urandom % 65536,
            $urandom % 256, $urandom % 256, $urandom % 256, $urandom % 256, $urandom % 65536);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk_i);
    @(negedge clk_i);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule